// File: doc/BRIEF.md
# I2C Register-Offset Random-Read Sequencer

This block carries out a whole random read from an I2C memory-style device on its own, with no software involved. It sits in front of a byte-level I2C master that reports each bus event as an 8-bit status code. The sequencer drives that master's register port directly. Each step follows the same pattern: the sequencer writes a command, then polls the status register at a fixed interval until the expected code appears. If the code does not appear within a bounded number of polls, the sequencer abandons the transfer.

A request gives a device address, a register offset of one or two bytes, a byte count and a one-cycle start pulse. The sequencer first re-initialises the master. It then sends the offset in a write phase, issues a repeated START and reads the requested number of bytes. It acknowledges every byte except the last. Each received byte appears on a valid/data output. The transfer ends either with a done pulse that carries the byte count, or with an error pulse. On an error, the last status code seen is held on an output.

Top module: `i2c_rand_read_seq`

## Requirements
- R1: After a start with a non-zero count, the first register writes are, in this order: word index 7 = 0x00 (soft reset), index 0 = 0x00, index 4 = 0x00, index 3 = 0x24 (bit-rate value), then index 2 = 0x40 (enable), which waits for status 0xF8. Index 1 is the data register, index 2 the control register, and index 3 the status register when read.
- R2: Control 0x60 (start plus enable) waits for status 0x08. The device address is then written to index 1 with bit 0 cleared, followed by control 0x40, and waits for 0x18.
- R3: With the two-byte offset option, offset bits 15:8 are sent before bits 7:0. With the one-byte option, only bits 7:0 are sent. Each offset byte is a data write followed by control 0x40, and each waits for 0x28.
- R4: Control 0x60 then waits for status 0x10. The address is then written with bit 0 set, followed by control 0x40, and waits for 0x40.
- R5: For a count N, there are N−1 reads that use control 0x44 and wait for 0x50, then one read that uses control 0x40 and waits for 0x58. After each expected code, the data register (index 1) is read once, and the byte appears on rx_data with a one-cycle rx_valid.
- R6: After the last byte, control 0x50 waits for 0xF8. Then done pulses for one cycle, with xfer_count equal to N. done and err never pulse together.
- R7: Each status read comes one poll interval after the previous step, where the interval is CLK_HZ/POLL_HZ cycles. Consecutive status reads within one step are exactly interval+2 cycles apart. At most POLL_MAX reads are made per step.
- R8: If a step reaches POLL_MAX reads with no match, the sequencer writes control 0x50, then pulses err with no done, and err_status holds the last status value read.
- R9: A start with count 0 gives an err pulse in the next cycle and err_status 0x00. No register access takes place, and busy stays low.
- R10: A start pulse while busy is ignored. The running transfer completes unchanged.
- R11: After reset, busy, done, err, rx_valid, both register strobes and err_status are all 0.
- R12: The register port never asserts write and read in the same cycle. It is silent whenever busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request pulse |
| dev_addr | input | 8 | Device address byte; bit 0 is replaced |
| reg_offset | input | 16 | Register offset inside the device |
| wide_offset | input | 1 | 1 sends both offset bytes, 0 only the low byte |
| byte_count | input | CNT_W | Number of bytes to read |
| busy | output | 1 | A transfer is in progress |
| reg_we | output | 1 | Master register write strobe |
| reg_re | output | 1 | Master register read strobe; data is returned in the next cycle |
| reg_idx | output | 3 | Master register word index |
| reg_wdata | output | 8 | Master register write data |
| reg_rdata | input | 8 | Master register read data, valid one cycle after reg_re |
| rx_valid | output | 1 | Received byte strobe |
| rx_data | output | 8 | Received byte |
| done | output | 1 | Successful completion pulse |
| xfer_count | output | CNT_W | Byte count of the accepted request |
| err | output | 1 | Failure pulse |
| err_status | output | 8 | Last status read when an error occurred |

## Verification
A behavioural model of the master answers each control write with the status code a real bus would produce. The model first returns a random number of pending codes, and it also logs every register write. Random requests vary the address, the offset, the offset width and the byte count. They separate the one-byte and two-byte offset paths, and they show whether the ACK/NACK split falls on the last byte for any count. Directed cases cover a count of one (a NACK-only read), a count of zero, a start issued during a busy transfer, and a status code held wrong during the address phase and during the final read. These cases tell a correct abort, with its STOP write and captured code, apart from a hang or a silent success. The spacing and the number of status polls are measured against the interval.

// File: rtl/rr_pkg.sv
package rr_pkg;

    localparam logic [2:0] IDX_OWN  = 3'd0;
    localparam logic [2:0] IDX_DATA = 3'd1;
    localparam logic [2:0] IDX_CTRL = 3'd2;
    localparam logic [2:0] IDX_STAT = 3'd3;
    localparam logic [2:0] IDX_EXT  = 3'd4;
    localparam logic [2:0] IDX_SRST = 3'd7;

    localparam logic [7:0] CTL_ACK   = 8'h04;
    localparam logic [7:0] CTL_STOP  = 8'h10;
    localparam logic [7:0] CTL_START = 8'h20;
    localparam logic [7:0] CTL_EN    = 8'h40;

    localparam logic [7:0] SC_IDLE    = 8'hF8;
    localparam logic [7:0] SC_START   = 8'h08;
    localparam logic [7:0] SC_RSTART  = 8'h10;
    localparam logic [7:0] SC_AW_ACK  = 8'h18;
    localparam logic [7:0] SC_WR_ACK  = 8'h28;
    localparam logic [7:0] SC_AR_ACK  = 8'h40;
    localparam logic [7:0] SC_RD_ACK  = 8'h50;
    localparam logic [7:0] SC_RD_NACK = 8'h58;

    localparam logic [7:0] RATE_VAL = 8'h24;

    typedef enum logic [3:0] {
        STP_EN, STP_START, STP_ADDRW, STP_OFFH, STP_OFFL,
        STP_RSTART, STP_ADDRR, STP_READ, STP_STOP
    } step_e;

    typedef enum logic [3:0] {
        PH_IDLE, PH_INIT, PH_DATA, PH_CTRL, PH_WAIT,
        PH_RDST, PH_CMP, PH_RDDAT, PH_CAP, PH_ABORT
    } phase_e;

    function automatic logic step_has_data(input step_e s);
        return (s == STP_ADDRW) || (s == STP_OFFH) || (s == STP_OFFL) || (s == STP_ADDRR);
    endfunction

endpackage

// File: rtl/rr_poll_timer.sv
module rr_poll_timer #(
    parameter int unsigned INTERVAL = 2500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int unsigned CW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        tick  = 1'b0;
        if (!run) begin
            cnt_d = '0;
        end else if (cnt_q == CW'(INTERVAL - 1)) begin
            tick  = 1'b1;
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/rr_retry_ctr.sv
module rr_retry_ctr #(
    parameter int unsigned LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic bump,
    output logic spent
);
    localparam int unsigned CW = $clog2(LIMIT + 1);

    logic [CW-1:0] n_d, n_q;

    always_comb begin
        n_d = n_q;
        if (clr)       n_d = '0;
        else if (bump) n_d = n_q + 1'b1;
    end

    // the poll now being compared is the final one allowed
    assign spent = (n_q == CW'(LIMIT - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) n_q <= '0;
        else        n_q <= n_d;
    end
endmodule

// File: rtl/rr_step_decode.sv
module rr_step_decode import rr_pkg::*; (
    input  step_e       step,
    input  logic [7:0]  dev,
    input  logic [15:0] off,
    input  logic        last,
    output logic [7:0]  data,
    output logic [7:0]  ctrl,
    output logic [7:0]  exp_st
);
    always_comb begin
        data   = 8'h00;
        ctrl   = CTL_EN;
        exp_st = SC_IDLE;
        case (step)
            STP_EN:     begin ctrl = CTL_EN;              exp_st = SC_IDLE;   end
            STP_START:  begin ctrl = CTL_START | CTL_EN;  exp_st = SC_START;  end
            STP_ADDRW:  begin data = {dev[7:1], 1'b0};    exp_st = SC_AW_ACK; end
            STP_OFFH:   begin data = off[15:8];           exp_st = SC_WR_ACK; end
            STP_OFFL:   begin data = off[7:0];            exp_st = SC_WR_ACK; end
            STP_RSTART: begin ctrl = CTL_START | CTL_EN;  exp_st = SC_RSTART; end
            STP_ADDRR:  begin data = {dev[7:1], 1'b1};    exp_st = SC_AR_ACK; end
            STP_READ: begin
                ctrl   = last ? CTL_EN : (CTL_EN | CTL_ACK);
                exp_st = last ? SC_RD_NACK : SC_RD_ACK;
            end
            STP_STOP:   begin ctrl = CTL_STOP | CTL_EN;   exp_st = SC_IDLE;   end
            default:    begin ctrl = CTL_EN;              exp_st = SC_IDLE;   end
        endcase
    end
endmodule

// File: rtl/i2c_rand_read_seq.sv
module i2c_rand_read_seq import rr_pkg::*; #(
    parameter int unsigned CLK_HZ   = 250_000_000,
    parameter int unsigned POLL_HZ  = 100_000,
    parameter int unsigned POLL_MAX = 1000,
    parameter int unsigned CNT_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [7:0]       dev_addr,
    input  logic [15:0]      reg_offset,
    input  logic             wide_offset,
    input  logic [CNT_W-1:0] byte_count,
    output logic             busy,
    output logic             reg_we,
    output logic             reg_re,
    output logic [2:0]       reg_idx,
    output logic [7:0]       reg_wdata,
    input  logic [7:0]       reg_rdata,
    output logic             rx_valid,
    output logic [7:0]       rx_data,
    output logic             done,
    output logic [CNT_W-1:0] xfer_count,
    output logic             err,
    output logic [7:0]       err_status
);
    localparam int unsigned RAW_IV   = CLK_HZ / POLL_HZ;
    localparam int unsigned INTERVAL = (RAW_IV > 0) ? RAW_IV : 1;

    typedef struct packed {
        phase_e           ph;
        step_e            step;
        logic [1:0]       isub;
        logic [7:0]       dev;
        logic [15:0]      off;
        logic             wide;
        logic [CNT_W-1:0] left;
        logic [CNT_W-1:0] total;
        logic [7:0]       last_st;
        logic             rx_v;
        logic [7:0]       rx_d;
        logic             done;
        logic             err;
    } seq_t;

    seq_t d, q;

    logic       tmr_run, tmr_tick;
    logic       try_clr, try_bump, try_spent;
    logic [7:0] dec_data, dec_ctrl, dec_exp;
    logic       last_byte;
    step_e      nxt_step;
    logic       nxt_finish;

    assign last_byte = (q.left == CNT_W'(1));

    rr_poll_timer #(.INTERVAL(INTERVAL)) i_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (tmr_run),
        .tick  (tmr_tick)
    );

    rr_retry_ctr #(.LIMIT(POLL_MAX)) i_retry (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (try_clr),
        .bump  (try_bump),
        .spent (try_spent)
    );

    rr_step_decode i_decode (
        .step   (q.step),
        .dev    (q.dev),
        .off    (q.off),
        .last   (last_byte),
        .data   (dec_data),
        .ctrl   (dec_ctrl),
        .exp_st (dec_exp)
    );

    // step order of the random read
    always_comb begin
        nxt_step   = q.step;
        nxt_finish = 1'b0;
        case (q.step)
            STP_EN:     nxt_step = STP_START;
            STP_START:  nxt_step = STP_ADDRW;
            STP_ADDRW:  nxt_step = q.wide ? STP_OFFH : STP_OFFL;
            STP_OFFH:   nxt_step = STP_OFFL;
            STP_OFFL:   nxt_step = STP_RSTART;
            STP_RSTART: nxt_step = STP_ADDRR;
            STP_ADDRR:  nxt_step = STP_READ;
            STP_READ:   nxt_step = last_byte ? STP_STOP : STP_READ;
            STP_STOP:   nxt_finish = 1'b1;
            default:    nxt_finish = 1'b1;
        endcase
    end

    always_comb begin
        d         = q;
        d.rx_v    = 1'b0;
        d.done    = 1'b0;
        d.err     = 1'b0;
        reg_we    = 1'b0;
        reg_re    = 1'b0;
        reg_idx   = IDX_OWN;
        reg_wdata = 8'h00;
        tmr_run   = 1'b0;
        try_clr   = 1'b0;
        try_bump  = 1'b0;

        case (q.ph)
            PH_IDLE: begin
                if (start) begin
                    if (byte_count == '0) begin
                        d.err     = 1'b1;
                        d.last_st = 8'h00;
                    end else begin
                        d.ph      = PH_INIT;
                        d.isub    = 2'd0;
                        d.step    = STP_EN;
                        d.dev     = dev_addr;
                        d.off     = reg_offset;
                        d.wide    = wide_offset;
                        d.left    = byte_count;
                        d.total   = byte_count;
                        d.last_st = 8'h00;
                    end
                end
            end
            PH_INIT: begin
                reg_we = 1'b1;
                case (q.isub)
                    2'd0:    begin reg_idx = IDX_SRST; reg_wdata = 8'h00;    end
                    2'd1:    begin reg_idx = IDX_OWN;  reg_wdata = 8'h00;    end
                    2'd2:    begin reg_idx = IDX_EXT;  reg_wdata = 8'h00;    end
                    default: begin reg_idx = IDX_STAT; reg_wdata = RATE_VAL; end
                endcase
                if (q.isub == 2'd3) begin
                    d.step = STP_EN;
                    d.ph   = PH_CTRL;
                end else begin
                    d.isub = q.isub + 2'd1;
                end
            end
            PH_DATA: begin
                reg_we    = 1'b1;
                reg_idx   = IDX_DATA;
                reg_wdata = dec_data;
                d.ph      = PH_CTRL;
            end
            PH_CTRL: begin
                reg_we    = 1'b1;
                reg_idx   = IDX_CTRL;
                reg_wdata = dec_ctrl;
                try_clr   = 1'b1;
                d.ph      = PH_WAIT;
            end
            PH_WAIT: begin
                tmr_run = 1'b1;
                if (tmr_tick) d.ph = PH_RDST;
            end
            PH_RDST: begin
                reg_re  = 1'b1;
                reg_idx = IDX_STAT;
                d.ph    = PH_CMP;
            end
            PH_CMP: begin
                d.last_st = reg_rdata;
                if (reg_rdata == dec_exp) begin
                    if (q.step == STP_READ) begin
                        d.ph = PH_RDDAT;
                    end else if (nxt_finish) begin
                        d.ph   = PH_IDLE;
                        d.done = 1'b1;
                    end else begin
                        d.step = nxt_step;
                        d.ph   = step_has_data(nxt_step) ? PH_DATA : PH_CTRL;
                    end
                end else if (try_spent) begin
                    d.ph = PH_ABORT;
                end else begin
                    try_bump = 1'b1;
                    d.ph     = PH_WAIT;
                end
            end
            PH_RDDAT: begin
                reg_re  = 1'b1;
                reg_idx = IDX_DATA;
                d.ph    = PH_CAP;
            end
            PH_CAP: begin
                d.rx_v = 1'b1;
                d.rx_d = reg_rdata;
                d.left = q.left - 1'b1;
                d.step = nxt_step;
                d.ph   = PH_CTRL;
            end
            PH_ABORT: begin
                reg_we    = 1'b1;
                reg_idx   = IDX_CTRL;
                reg_wdata = CTL_STOP | CTL_EN;
                d.err     = 1'b1;
                d.ph      = PH_IDLE;
            end
            default: d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy       = (q.ph != PH_IDLE);
    assign rx_valid   = q.rx_v;
    assign rx_data    = q.rx_d;
    assign done       = q.done;
    assign err        = q.err;
    assign xfer_count = q.total;
    assign err_status = q.last_st;
endmodule

// File: rtl/rr_seq_chk.sv
module rr_seq_chk #(
    parameter int unsigned CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [CNT_W-1:0] byte_count,
    input logic             busy,
    input logic             reg_we,
    input logic             reg_re,
    input logic [2:0]       reg_idx,
    input logic [7:0]       reg_wdata,
    input logic             rx_valid,
    input logic             done,
    input logic [CNT_W-1:0] xfer_count,
    input logic             err
);
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(reg_we && reg_re)); // R12
    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> (!reg_we && !reg_re)); // R12
    AST_ZERO_REJECT: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy && byte_count == '0) |=> (err && !busy)); // R9
    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n) busy |=> $stable(xfer_count)); // R10
    AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(done && err)); // R6
    AST_RX_IN_XFER: assert property (@(posedge clk) disable iff (!rst_n) rx_valid |-> busy); // R5
    AST_ABORT_STOP: assert property (@(posedge clk) disable iff (!rst_n) (err && $past(busy)) |-> $past(reg_we && reg_idx == 3'd2 && reg_wdata == 8'h50)); // R8
endmodule

bind i2c_rand_read_seq rr_seq_chk #(.CNT_W(CNT_W)) i_rr_seq_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .byte_count (byte_count),
    .busy       (busy),
    .reg_we     (reg_we),
    .reg_re     (reg_re),
    .reg_idx    (reg_idx),
    .reg_wdata  (reg_wdata),
    .rx_valid   (rx_valid),
    .done       (done),
    .xfer_count (xfer_count),
    .err        (err)
);

// File: tb/test_i2c_rand_read_seq.sv
module test_i2c_rand_read_seq;
    localparam int CLK_HZ   = 500_000;
    localparam int POLL_HZ  = 100_000;
    localparam int IV       = CLK_HZ / POLL_HZ;
    localparam int POLL_MAX = 6;
    localparam int CNT_W    = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [7:0] dev_addr = 8'h00;
    logic [15:0] reg_offset = 16'h0;
    logic wide_offset = 1'b0;
    logic [CNT_W-1:0] byte_count = '0;
    logic busy, reg_we, reg_re, rx_valid, done, err;
    logic [2:0] reg_idx;
    logic [7:0] reg_wdata, rx_data, err_status;
    logic [7:0] reg_rdata = 8'h00;
    logic [CNT_W-1:0] xfer_count;

    always #2 clk = ~clk;

    i2c_rand_read_seq #(.CLK_HZ(CLK_HZ), .POLL_HZ(POLL_HZ), .POLL_MAX(POLL_MAX), .CNT_W(CNT_W))
    i_i2c_rand_read_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .dev_addr(dev_addr), .reg_offset(reg_offset),
        .wide_offset(wide_offset), .byte_count(byte_count), .busy(busy), .reg_we(reg_we),
        .reg_re(reg_re), .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rx_valid(rx_valid), .rx_data(rx_data), .done(done), .xfer_count(xfer_count),
        .err(err), .err_status(err_status)
    );

    int vectors = 0;
    int miscmp  = 0;

    // stimulus-owned settings read by the master model
    logic [7:0]  cur_dev = 8'h00;
    logic [15:0] cur_off = 16'h0;
    int          lat = 0;
    int          fault_at = -1;

    function automatic logic [7:0] dev_byte(input logic [7:0] dv, input logic [15:0] o, input int i);
        return (dv ^ o[7:0] ^ {o[14:8], o[15]}) + 8'(i * 29 + 3);
    endfunction

    // master model and monitor
    logic [10:0] log_mem [0:63];
    logic [7:0]  rx_buf  [0:63];
    int log_n = 0, rx_n = 0, wr_total = 0, rd_total = 0;
    int cyc = 0, prev_cyc = 0, step_reads = 0, last_step_reads = 0, gap_bad = 0, ctrl_n = 0;
    bit have_prev = 0, m_started = 0, m_addr_next = 0, m_reading = 0, m_dw = 0;
    int m_pend = 0, rd_i = 0;
    logic [7:0] m_stat = 8'hF8, m_data = 8'h00, m_rx = 8'h00;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rx_valid) begin
            rx_buf[rx_n[5:0]] <= rx_data;
            rx_n <= rx_n + 1;
        end
        if (reg_re) begin
            rd_total <= rd_total + 1;
            if (reg_idx == 3'd3) begin
                reg_rdata <= (m_pend > 0) ? 8'hF0 : m_stat;
                if (m_pend > 0) m_pend <= m_pend - 1;
                if (have_prev && (cyc - prev_cyc) != IV + 2) gap_bad <= gap_bad + 1;
                prev_cyc   <= cyc;
                have_prev  <= 1'b1;
                step_reads <= step_reads + 1;
            end else begin
                reg_rdata <= m_rx;
            end
        end
        if (reg_we) begin
            wr_total <= wr_total + 1;
            if (reg_idx == 3'd7) begin
                log_mem[0] <= {reg_idx, reg_wdata};
                log_n <= 1; rx_n <= 0; ctrl_n <= 0; rd_i <= 0; gap_bad <= 0;
                m_started <= 0; m_reading <= 0; m_addr_next <= 0; m_dw <= 0;
            end else begin
                log_mem[log_n[5:0]] <= {reg_idx, reg_wdata};
                log_n <= log_n + 1;
            end
            if (reg_idx == 3'd1) begin
                m_data <= reg_wdata;
                m_dw   <= 1'b1;
            end
            if (reg_idx == 3'd2) begin
                ctrl_n          <= ctrl_n + 1;
                m_pend          <= lat;
                m_dw            <= 1'b0;
                have_prev       <= 1'b0;
                last_step_reads <= step_reads;
                step_reads      <= 0;
                if (ctrl_n == fault_at) begin
                    m_stat <= 8'h20;
                end else if (reg_wdata == 8'h50) begin
                    m_stat <= 8'hF8; m_started <= 0; m_reading <= 0;
                end else if (reg_wdata == 8'h60) begin
                    m_stat <= m_started ? 8'h10 : 8'h08; m_started <= 1; m_addr_next <= 1;
                end else if (reg_wdata == 8'h44) begin
                    m_stat <= 8'h50; m_rx <= dev_byte(cur_dev, cur_off, rd_i); rd_i <= rd_i + 1;
                end else if (m_dw) begin
                    if (m_addr_next) begin
                        m_stat <= m_data[0] ? 8'h40 : 8'h18;
                        m_addr_next <= 0;
                        if (m_data[0]) m_reading <= 1;
                    end else begin
                        m_stat <= 8'h28;
                    end
                end else if (m_reading) begin
                    m_stat <= 8'h58; m_rx <= dev_byte(cur_dev, cur_off, rd_i); rd_i <= rd_i + 1;
                end else begin
                    m_stat <= 8'hF8;
                end
            end
        end
    end

    // expected write list
    logic [10:0] exp_log [0:63];
    string       exp_tag [0:63];
    int exp_n;

    task automatic push(input logic [2:0] ix, input logic [7:0] v, input string tg);
        exp_log[exp_n[5:0]] = {ix, v};
        exp_tag[exp_n[5:0]] = tg;
        exp_n++;
    endtask

    task automatic build_exp(input logic [7:0] dv, input logic [15:0] o, input bit wd,
                             input int n, input int flt);
        int cn = 0;
        bit cut = 0;
        logic [7:0] ctl [0:31];
        int nc = 0;
        exp_n = 0;
        push(3'd7, 8'h00, "R1"); push(3'd0, 8'h00, "R1"); push(3'd4, 8'h00, "R1"); push(3'd3, 8'h24, "R1");
        // sequence of steps encoded as (has data, data, ctrl)
        for (int s = 0; s < 9 + n; s++) begin
            bit hd = 0; logic [7:0] dt = 8'h00; logic [7:0] cv = 8'h40; string tg = "R1";
            if (cut) break;
            case (s)
                0: begin cv = 8'h40; tg = "R1"; end
                1: begin cv = 8'h60; tg = "R2"; end
                2: begin hd = 1; dt = {dv[7:1], 1'b0}; tg = "R2"; end
                3: begin hd = wd; dt = o[15:8]; tg = "R3"; end
                4: begin hd = 1; dt = o[7:0]; tg = "R3"; end
                5: begin cv = 8'h60; tg = "R4"; end
                6: begin hd = 1; dt = {dv[7:1], 1'b1}; tg = "R4"; end
                default: begin
                    if (s == 7 + n) begin cv = 8'h50; tg = "R6"; end
                    else if (s == 6 + n) begin cv = 8'h40; tg = "R5"; end
                    else begin cv = 8'h44; tg = "R5"; end
                end
            endcase
            if (s == 3 && !wd) continue;
            if (s == 8 + n) break;
            if (hd) push(3'd1, dt, tg);
            push(3'd2, cv, tg);
            if (cn == flt) begin
                push(3'd2, 8'h50, "R8");
                cut = 1;
            end
            cn++;
        end
        nc = nc + 0;
        ctl[0] = 8'h00;
    endtask

    task automatic chk(input bit ok, input string tg, input string what, input longint act, input longint expv);
        vectors++;
        if (!ok) begin
            miscmp++;
            $display("FAIL %s %s: actual %0h expected %0h", tg, what, act, expv);
        end
    endtask

    task automatic run_txn(input logic [7:0] dv, input logic [15:0] o, input bit wd, input int n,
                           input int flt, input int lt, input bit poke);
        bit got_done = 0, got_err = 0;
        cur_dev = dv; cur_off = o; fault_at = flt; lat = lt;
        build_exp(dv, o, wd, n, flt);
        @(negedge clk);
        dev_addr = dv; reg_offset = o; wide_offset = wd; byte_count = CNT_W'(n); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 20000; i++) begin
            if (poke && i == 20) begin
                start = 1'b1; byte_count = '0; dev_addr = 8'h00;
            end else if (poke && i == 21) begin
                start = 1'b0; byte_count = CNT_W'(n); dev_addr = dv;
            end
            if (done || err) begin got_done = done; got_err = err; break; end
            @(negedge clk);
        end
        if (flt < 0) begin
            chk(got_done && !got_err, poke ? "R10" : "R6", "done pulse", {got_done, got_err}, 2'b10);
            chk(xfer_count == CNT_W'(n), "R6", "xfer_count", xfer_count, n);
            chk(rx_n == n, "R5", "bytes received", rx_n, n);
            for (int k = 0; k < n && k < rx_n; k++)
                chk(rx_buf[k] == dev_byte(dv, o, k), "R5", "rx byte", rx_buf[k], dev_byte(dv, o, k));
        end else begin
            chk(got_err && !got_done, "R8", "err pulse", {got_done, got_err}, 2'b01);
            chk(err_status == 8'h20, "R8", "err_status", err_status, 8'h20);
            chk(last_step_reads == POLL_MAX, "R7", "status polls in failing step", last_step_reads, POLL_MAX);
        end
        chk(gap_bad == 0, "R7", "poll spacing errors", gap_bad, 0);
        chk(log_n == exp_n, "R1", "register write count", log_n, exp_n);
        for (int k = 0; k < exp_n && k < log_n; k++)
            chk(log_mem[k] == exp_log[k], exp_tag[k], "register write", log_mem[k], exp_log[k]);
        @(negedge clk);
    endtask

    bit finished = 0;

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            miscmp++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
            $finish;
        end
    end

    initial begin
        int w0, r0;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        chk(!busy && !done && !err && !rx_valid && !reg_we && !reg_re && err_status == 8'h00,
            "R11", "reset outputs", {busy, done, err, rx_valid, reg_we, reg_re}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: zero count
        w0 = wr_total; r0 = rd_total;
        dev_addr = 8'hA0; byte_count = '0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(err && !busy, "R9", "zero-count err", {err, busy}, 2'b10);
        chk(err_status == 8'h00, "R9", "zero-count err_status", err_status, 0);
        repeat (5) @(negedge clk);
        chk(wr_total == w0 && rd_total == r0 && !busy, "R9", "bus accesses", wr_total - w0 + rd_total - r0, 0);

        run_txn(8'hA1, 16'h12C4, 1'b1, 1, -1, 0, 1'b0);   // count 1: only the NACK read
        run_txn(8'h50, 16'h0077, 1'b0, 3, -1, 2, 1'b0);   // one-byte offset
        run_txn(8'hA0, 16'h3355, 1'b1, 2, 2, 1, 1'b0);    // address NACK forever
        run_txn(8'hAE, 16'h0009, 1'b0, 2, 7, 0, 1'b0);    // final read never matches
        run_txn(8'hA4, 16'hBEEF, 1'b1, 4, -1, 1, 1'b1);   // R10 start while busy

        for (int t = 0; t < 16; t++) begin
            logic [7:0] dv = 8'($urandom);
            logic [15:0] o = 16'($urandom);
            bit wd = 1'($urandom);
            int n = 1 + int'($urandom % 6);
            int lt = int'($urandom % 4);
            run_txn(dv, o, wd, n, -1, lt, 1'b0);
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
        $finish;
    end
endmodule